// File: doc/BRIEF.md
# Processor Core Power-Up Sequencer

This block brings one secondary processor core out of power-down with no software timing. A one-cycle start pulse launches a fixed release sequence. The block first drives a voltage-rail control code and lets the rail settle. It then steps a 9-bit core power-control word through a clamp, sleep and reset release order. Every step holds for a minimum settle time before the next change.

Each settle time is given in nanoseconds and turned into a clock-cycle count from a clock-frequency parameter given in kHz. The count is always rounded up, so no wait is ever shorter than its minimum. All outputs come from registers, so each step changes the outputs on exactly one clock edge. When the sequence ends, the block raises a done flag and holds the final word until the next start.

Top module: `core_pwrup_seq`

## Requirements
- R1: After reset, the rail code, the power-control word, busy and done are all zero.
- R2: On the first clock edge where start is sampled high while idle or done, the rail code becomes 0xA4, busy goes high, done goes low and the word becomes 0x000. The word stays 0x000 for ceil(512 us × f) cycles.
- R3: The word bits are: bit 8 PLL clamp, bit 7 core powered up, bit 5 power-on reset, bit 4 core reset, bit 3 L2 data sleep, bit 0 output clamp. After the rail wait, the word becomes 0x109 for exactly one cycle.
- R4: The word then becomes 0x101 (L2 sleep released) for ceil(300 ns × f) cycles.
- R5: The word then becomes 0x121 (power-on reset asserted) for ceil(2 us × f) cycles.
- R6: The word then becomes 0x120 (output clamp released) for ceil(2 us × f) cycles.
- R7: The word then becomes 0x100 (power-on reset released) for ceil(100 us × f) cycles.
- R8: The word then becomes 0x180, busy goes low and done goes high on the same edge. The word, the rail code 0xA4 and done then stay unchanged until the next start.
- R9: A start pulse sampled while busy is high has no effect on the word, the rail code or any step's length.
- R10: Each cycle count is the exact value of the time × frequency product rounded up, with a minimum of one cycle.
- R11: Once the word leaves 0x000 in a sequence, bit 8 stays set and bit 4 stays clear until the next start.
- R12: A start pulse after done runs the complete sequence again from the rail step, with the same word values and step lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that launches the sequence |
| rail_code_o | output | 8 | Rail voltage-control code |
| pwr_word_o | output | 9 | Core power-control word |
| busy_o | output | 1 | High while the sequence is running |
| done_o | output | 1 | High after the final step, until the next start |

## Verification
A wrong step state shows up at the ports on the next edge as an unexpected word value. The bench compares each word against the expected release order, so an out-of-order or skipped step is caught within one cycle. A wrong timer load or rounding error does not change any word value. It only makes one step one or more cycles too long or too short, so the bench measures the exact hold length of every step, including the rounded-up ones. A start pulse that leaks into a running sequence would reload the timer or restart the order, and that too appears as a changed hold length or a word that drops back to 0x000.

// File: rtl/core_pwrup_pkg.sv
package core_pwrup_pkg;

    localparam int WORD_W = 9;
    localparam int RAIL_W = 8;

    localparam int BIT_PLL_CLAMP = 8;
    localparam int BIT_CORE_UP   = 7;
    localparam int BIT_POR       = 5;
    localparam int BIT_CORE_RST  = 4;
    localparam int BIT_L2_SLEEP  = 3;
    localparam int BIT_OUT_CLAMP = 0;

    localparam logic [RAIL_W-1:0] RAIL_ON_CODE = 8'hA4;

    localparam longint unsigned RAIL_SETTLE_NS = 512_000;
    localparam longint unsigned L2_WAKE_NS     = 300;
    localparam longint unsigned POR_ON_NS      = 2_000;
    localparam longint unsigned UNCLAMP_NS     = 2_000;
    localparam longint unsigned POR_OFF_NS     = 100_000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAIL,
        ST_CLAMP_ALL,
        ST_L2_WAKE,
        ST_POR_ON,
        ST_UNCLAMP,
        ST_POR_OFF,
        ST_DONE
    } seq_state_e;

    function automatic longint unsigned ns_to_cycles(longint unsigned ns,
                                                     longint unsigned khz);
        longint unsigned c;
        c = (ns * khz + 64'd999_999) / 64'd1_000_000;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/core_pwrup_timer.sv
module core_pwrup_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/core_pwrup_steps.sv
module core_pwrup_steps
    import core_pwrup_pkg::*;
#(
    parameter longint unsigned CLK_KHZ = 100_000,
    parameter int              CNT_W   = 16
) (
    input  seq_state_e        step_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  hold_m1_o
);
    localparam longint unsigned C_RAIL    = ns_to_cycles(RAIL_SETTLE_NS, CLK_KHZ);
    localparam longint unsigned C_L2      = ns_to_cycles(L2_WAKE_NS, CLK_KHZ);
    localparam longint unsigned C_POR_ON  = ns_to_cycles(POR_ON_NS, CLK_KHZ);
    localparam longint unsigned C_UNCLAMP = ns_to_cycles(UNCLAMP_NS, CLK_KHZ);
    localparam longint unsigned C_POR_OFF = ns_to_cycles(POR_OFF_NS, CLK_KHZ);

    always_comb begin
        word_o    = '0;
        hold_m1_o = '0;
        unique case (step_i)
            ST_RAIL: hold_m1_o = CNT_W'(C_RAIL - 1);
            ST_CLAMP_ALL: begin
                word_o[BIT_PLL_CLAMP] = 1'b1;
                word_o[BIT_L2_SLEEP]  = 1'b1;
                word_o[BIT_OUT_CLAMP] = 1'b1;
            end
            ST_L2_WAKE: begin
                word_o[BIT_PLL_CLAMP] = 1'b1;
                word_o[BIT_OUT_CLAMP] = 1'b1;
                hold_m1_o = CNT_W'(C_L2 - 1);
            end
            ST_POR_ON: begin
                word_o[BIT_PLL_CLAMP] = 1'b1;
                word_o[BIT_POR]       = 1'b1;
                word_o[BIT_OUT_CLAMP] = 1'b1;
                hold_m1_o = CNT_W'(C_POR_ON - 1);
            end
            ST_UNCLAMP: begin
                word_o[BIT_PLL_CLAMP] = 1'b1;
                word_o[BIT_POR]       = 1'b1;
                hold_m1_o = CNT_W'(C_UNCLAMP - 1);
            end
            ST_POR_OFF: begin
                word_o[BIT_PLL_CLAMP] = 1'b1;
                hold_m1_o = CNT_W'(C_POR_OFF - 1);
            end
            ST_DONE: begin
                word_o[BIT_PLL_CLAMP] = 1'b1;
                word_o[BIT_CORE_UP]   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
    import core_pwrup_pkg::*;
#(
    parameter longint unsigned CLK_KHZ = 100_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [RAIL_W-1:0] rail_code_o,
    output logic [WORD_W-1:0] pwr_word_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam longint unsigned MAX_CYC = ns_to_cycles(RAIL_SETTLE_NS, CLK_KHZ);
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [RAIL_W-1:0] rail;
        logic [WORD_W-1:0] word;
        logic              busy;
        logic              done;
    } seq_regs_t;

    seq_regs_t         regs_d, regs_q;
    seq_state_e        step_sel;
    logic [WORD_W-1:0] tbl_word;
    logic [CNT_W-1:0]  tbl_hold_m1;
    logic              tmr_load;
    logic              tmr_expired;

    always_comb begin
        unique case (regs_q.st)
            ST_RAIL:      step_sel = ST_CLAMP_ALL;
            ST_CLAMP_ALL: step_sel = ST_L2_WAKE;
            ST_L2_WAKE:   step_sel = ST_POR_ON;
            ST_POR_ON:    step_sel = ST_UNCLAMP;
            ST_UNCLAMP:   step_sel = ST_POR_OFF;
            ST_POR_OFF:   step_sel = ST_DONE;
            default:      step_sel = ST_RAIL;
        endcase
    end

    core_pwrup_steps #(.CLK_KHZ(CLK_KHZ), .CNT_W(CNT_W)) steps_i (
        .step_i    (step_sel),
        .word_o    (tbl_word),
        .hold_m1_o (tbl_hold_m1)
    );

    always_comb begin
        regs_d   = regs_q;
        tmr_load = 1'b0;
        if (!regs_q.busy) begin
            if (start_i) begin
                regs_d.st   = ST_RAIL;
                regs_d.rail = RAIL_ON_CODE;
                regs_d.word = tbl_word;
                regs_d.busy = 1'b1;
                regs_d.done = 1'b0;
                tmr_load    = 1'b1;
            end
        end else if (tmr_expired) begin
            regs_d.st   = step_sel;
            regs_d.word = tbl_word;
            if (step_sel == ST_DONE) begin
                regs_d.busy = 1'b0;
                regs_d.done = 1'b1;
            end else begin
                tmr_load = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{st: ST_IDLE, rail: '0, word: '0, busy: 1'b0, done: 1'b0};
        else        regs_q <= regs_d;
    end

    core_pwrup_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tbl_hold_m1),
        .expired_o  (tmr_expired)
    );

    assign rail_code_o = regs_q.rail;
    assign pwr_word_o  = regs_q.word;
    assign busy_o      = regs_q.busy;
    assign done_o      = regs_q.done;

    // R9: a running step is held until the timer runs out, whatever start does
    assert_step_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !tmr_expired |=> $stable(pwr_word_o) && $stable(rail_code_o) && busy_o);

    // R11: PLL clamp, once set in a run, is kept while busy and into done
    assert_pll_clamp_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && pwr_word_o[BIT_PLL_CLAMP] |=> pwr_word_o[BIT_PLL_CLAMP]);

    // R11: core reset never driven
    assert_no_core_rst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_word_o[BIT_CORE_RST]);

    // R8: done arrives with the powered-up word and busy dropped
    assert_done_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (pwr_word_o == 9'h180) && !busy_o);

    // R8: done holds everything until a new start
    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o && $stable(pwr_word_o) && $stable(rail_code_o));

    // R2: start from idle or done begins the rail step
    assert_start_rail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o && (rail_code_o == 8'hA4) && (pwr_word_o == '0));
endmodule

// File: tb/core_pwrup_seq_tb.sv
module core_pwrup_seq_tb_top;
    localparam longint unsigned KHZ = 13_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] rail;
    logic [8:0] word;
    logic       busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    core_pwrup_seq #(.CLK_KHZ(KHZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .rail_code_o(rail), .pwr_word_o(word), .busy_o(busy), .done_o(done)
    );

    function automatic int exp_cyc(longint unsigned ns);
        longint unsigned c;
        c = (ns * KHZ + 64'd999_999) / 64'd1_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    task automatic check(string req, longint unsigned act, longint unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Measures how long word stays at exp_w; may inject ignored start pulses
    task automatic hold_len(input logic [8:0] exp_w, input bit inject,
                            output int len, output int bad_bits);
        len = 0;
        bad_bits = 0;
        while (word == exp_w && busy && len < 20000) begin
            if (exp_w != 9'h000 && (!word[8] || word[4])) bad_bits++;
            len++;
            start = inject && ($urandom % 5 == 0);
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    task automatic run_sequence(input bit inject, input string tag);
        logic [8:0] words [6];
        int holds [6];
        int len, bad, bad_total;
        words = '{9'h000, 9'h109, 9'h101, 9'h121, 9'h120, 9'h100};
        holds = '{exp_cyc(512_000), 1, exp_cyc(300), exp_cyc(2_000),
                  exp_cyc(2_000), exp_cyc(100_000)};
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({"R2 rail code ", tag}, rail, 8'hA4);
        check({"R2 busy ", tag}, busy, 1);
        check({"R2 done low ", tag}, done, 0);
        check({"R2 word cleared ", tag}, word, 9'h000);
        bad_total = 0;
        for (int i = 0; i < 6; i++) begin
            hold_len(words[i], inject, len, bad);
            bad_total += bad;
            case (i)
                0: check({"R2 rail wait ", tag}, len, holds[i]);
                1: check({"R3 clamp-all step ", tag}, len, holds[i]);
                2: check({"R4 R10 L2 wake step ", tag}, len, holds[i]);
                3: check({"R5 R10 por on step ", tag}, len, holds[i]);
                4: check({"R6 R10 unclamp step ", tag}, len, holds[i]);
                default: check({"R7 R10 por off step ", tag}, len, holds[i]);
            endcase
            if (i < 5) check({"R3 next word ", tag}, word, words[i+1]);
        end
        check({"R8 final word ", tag}, word, 9'h180);
        check({"R8 busy low ", tag}, busy, 0);
        check({"R8 done high ", tag}, done, 1);
        check({"R11 clamp and core reset ", tag}, bad_total, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("R1 rail reset", rail, 0);
        check("R1 word reset", word, 0);
        check("R1 busy reset", busy, 0);
        check("R1 done reset", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after release", {busy, done, word}, 0);

        run_sequence(1'b0, "run1");

        begin
            int wait_n;
            wait_n = 20 + ($urandom % 60);
            repeat (wait_n) @(negedge clk);
        end
        check("R8 done persists", done, 1);
        check("R8 word persists", word, 9'h180);
        check("R8 rail persists", rail, 8'hA4);

        // R9 and R12: rerun with random start pulses during busy
        run_sequence(1'b1, "run2 R9 R12");

        finished = 1;
        report();
    end

    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end
endmodule